// File: doc/BRIEF.md
# Writeback frame control sequencer

This block holds the single control and status word of a display writeback engine and runs the per-frame sequence around it. Software writes the word to configure the engine and to request a frame. The block then reports the frame as busy, lets the memory write path issue writes, and counts the write acknowledgements still to come. When the frame ends, the block waits for that count to reach zero before it reports idle. The frame ends either normally, when the pixel path signals end of frame, or early, when software asks for an abort.

The word carries a frame-start request, a busy flag, an idle interrupt enable, an abort request, a debug option that repeats the frame-start indication at end of frame, and a power-down flag for the internal line memory. The other configuration bits are stored for the data path. The top ten bits are a fixed identification value. The interrupt is a level. It is raised when the engine goes idle and enable is set, and software clears it by writing the word back with enable cleared.

The pixel data path and the address generation are not part of the block. They appear only as the end-of-frame, write-issue and write-acknowledge inputs.

Top module: `wb_frame_seq`

## Requirements
- R1: After reset, reg_rdata reads 0x5440_0000, and irq, frame_start and wr_allow are 0.
- R2: reg_rdata[31:24] always reads 0x54 and reg_rdata[23:22] always reads 2'b01, whatever is written.
- R3: A write with bit 0 set, while idle and with bit 21 of the written word clear, starts a frame. Busy (bit 1) reads 1 from the next cycle, frame_start is high for exactly that one cycle, wr_allow goes high, and bit 0 always reads 0.
- R4: A start request is ignored while busy, and also when the written word has bit 21 (power down) set. In that case no frame_start pulse is produced and busy does not change.
- R5: Bits 21:15 and 13:2 read back as last written. Bits 14 and 0 read 0. Bit 1 shows busy, and writes to it have no effect.
- R6: After the frame ends, busy stays 1 until every counted write has been acknowledged. It reads 0 two cycles after the later of the end event and the last acknowledgement.
- R7: wr_allow is high only while busy and before the end event. A wr_issue pulse while wr_allow is low is not counted.
- R8: A write with bit 14 set while busy ends the frame. wr_allow is 0 from the next cycle and busy drains as in R6. The same write while idle changes nothing.
- R9: With bit 15 set, an end-of-frame input during a busy, not-ended frame pulses frame_start in the next cycle. With bit 15 clear, it does not.
- R10: When busy falls, a pending flag is set. irq equals pending AND bit 2, and it holds while both are set.
- R11: Writing the word with bit 2 clear drops irq in the next cycle and discards the pending flag, so setting bit 2 again does not raise irq.
- R12: An accepted start clears the pending flag. A write with bit 2 clear in the same cycle as busy falls leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control and status readback |
| eof_in | input | 1 | End of frame from the pixel path |
| wr_issue | input | 1 | A memory write is issued |
| wr_ack | input | 1 | A memory write acknowledgement returned |
| wr_allow | output | 1 | Memory writes may be issued |
| frame_start | output | 1 | One-cycle frame-start indication |
| irq | output | 1 | Level idle interrupt |

## Verification
Two events can land in the same cycle: the frame going idle, and software writing the word to acknowledge the interrupt. The bench provokes this by ending a frame with no outstanding writes, then placing a write with enable clear on the exact cycle in which busy falls. It judges the result by irq staying low in that cycle and in every later cycle, including after enable is set again. A second coincidence, an abort landing on top of outstanding writes, is swept across zero to three pending acknowledgements. Each case is judged by the cycle in which busy falls.

// File: rtl/wb_frame_seq.sv
module wb_frame_seq #(
  parameter int          CW    = 4,
  parameter logic [7:0]  ID_HI = 8'h54,
  parameter logic [1:0]  ID_LO = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eof_in,
  input  logic        wr_issue,
  input  logic        wr_ack,
  output logic        wr_allow,
  output logic        frame_start,
  output logic        irq
);

  localparam logic [31:0] KEEP  = 32'h003F_BFFC;
  localparam logic [31:0] IDW   = {ID_HI, ID_LO, 22'd0};
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [31:0]   ctrl_q;
  logic          busy_q, ending_q, pend_q, fs_q;
  logic [CW-1:0] outs_q;

  wire ie_q    = ctrl_q[2];
  wire dbg_q   = ctrl_q[15];
  wire go_ok   = reg_wr & reg_wdata[0] & ~busy_q & ~reg_wdata[21];
  wire abort_h = reg_wr & reg_wdata[14] & busy_q & ~ending_q;
  wire eof_h   = eof_in & busy_q & ~ending_q;
  wire done    = busy_q & ending_q & (outs_q == '0);
  wire take    = wr_issue & wr_allow;
  wire ackv    = wr_ack & (outs_q != '0);

  assign wr_allow    = busy_q & ~ending_q;
  assign frame_start = fs_q;
  assign irq         = pend_q & ie_q;
  assign reg_rdata   = IDW | (ctrl_q & KEEP) | {30'd0, busy_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      busy_q   <= 1'b0;
      ending_q <= 1'b0;
      pend_q   <= 1'b0;
      fs_q     <= 1'b0;
      outs_q   <= '0;
    end else begin
      if (reg_wr) ctrl_q <= reg_wdata;

      if (go_ok)     busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;

      if (go_ok)                 ending_q <= 1'b0;
      else if (eof_h | abort_h)  ending_q <= 1'b1;
      else if (done)             ending_q <= 1'b0;

      fs_q <= go_ok | (eof_h & dbg_q & ~abort_h);

      if (done)       pend_q <= 1'b1;
      else if (go_ok) pend_q <= 1'b0;
      else if (!ie_q) pend_q <= 1'b0;

      case ({take, ackv})
        2'b10:   outs_q <= outs_q + ONE;
        2'b01:   outs_q <= outs_q - ONE;
        default: outs_q <= outs_q;
      endcase
    end
  end

endmodule

module wb_frame_seq_chk #(
  parameter int         CW    = 4,
  parameter logic [9:0] IDV   = 10'h151
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic          wd_go,
  input logic          wd_ie,
  input logic          wd_abort,
  input logic          wd_pd,
  input logic [9:0]    rd_id,
  input logic          rd_go,
  input logic          rd_busy,
  input logic          rd_ie,
  input logic          frame_start,
  input logic          wr_allow,
  input logic          irq,
  input logic [CW-1:0] outs
);

  p_id_const_r2: assert property (@(posedge clk) disable iff (!rst_n) rd_id == IDV);

  p_go_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) !rd_go);

  p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wd_go && !rd_busy && !wd_pd |=> rd_busy && frame_start && wr_allow);

  p_pd_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wd_go && !rd_busy && wd_pd |=> !rd_busy && !frame_start);

  p_drain_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_busy) |-> outs == '0);

  p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wd_abort && rd_busy |=> !wr_allow);

  p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (!rst_n) irq |-> rd_ie);

  p_irq_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !rd_busy);

  p_ack_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !wd_ie |=> !irq);

endmodule

bind wb_frame_seq wb_frame_seq_chk #(.CW(CW), .IDV({ID_HI, ID_LO})) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr          (reg_wr),
  .wd_go       (reg_wdata[0]),
  .wd_ie       (reg_wdata[2]),
  .wd_abort    (reg_wdata[14]),
  .wd_pd       (reg_wdata[21]),
  .rd_id       (reg_rdata[31:22]),
  .rd_go       (reg_rdata[0]),
  .rd_busy     (reg_rdata[1]),
  .rd_ie       (reg_rdata[2]),
  .frame_start (frame_start),
  .wr_allow    (wr_allow),
  .irq         (irq),
  .outs        (outs_q)
);

// File: tb/wb_frame_seq_tb.sv
module wb_frame_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, eof_in = 1'b0, wr_issue = 1'b0, wr_ack = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic wr_allow, frame_start, irq;

  localparam logic [31:0] IDW  = 32'h5440_0000;
  localparam logic [31:0] KEEP = 32'h003F_BFFC;

  int errs = 0, checks = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  wb_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eof_in(eof_in), .wr_issue(wr_issue),
    .wr_ack(wr_ack), .wr_allow(wr_allow), .frame_start(frame_start), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_word(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_eof();
    eof_in = 1'b1; step(); eof_in = 1'b0;
  endtask

  task automatic run_frame(input int n, input bit ab, input bit ie);
    logic [31:0] iew;
    iew = ie ? 32'h4 : 32'h0;
    wr_word(32'h1 | iew);
    chk("R3 busy after start", {31'd0, reg_rdata[1]}, 1);
    chk("R3 start pulse", {31'd0, frame_start}, 1);
    chk("R7 allow after start", {31'd0, wr_allow}, 1);
    chk("R3 go reads 0", {31'd0, reg_rdata[0]}, 0);
    step();
    chk("R3 pulse one cycle", {31'd0, frame_start}, 0);
    for (int i = 0; i < n; i++) begin
      wr_issue = 1'b1; step(); wr_issue = 1'b0;
    end
    if (ab) wr_word(32'h4000 | iew);
    else pulse_eof();
    chk(ab ? "R8 allow off after abort" : "R7 allow off after eof", {31'd0, wr_allow}, 0);
    chk("R9 no pulse without debug", {31'd0, frame_start}, 0);
    if (n > 0) begin
      wr_issue = 1'b1; step(); wr_issue = 1'b0;
      for (int i = 0; i < n; i++) begin
        chk("R6 busy while draining", {31'd0, reg_rdata[1]}, 1);
        wr_ack = 1'b1; step(); wr_ack = 1'b0;
      end
    end
    chk("R6 busy one cycle after close", {31'd0, reg_rdata[1]}, 1);
    chk("R10 no irq while busy", {31'd0, irq}, 0);
    step();
    chk("R6 idle after drain", {31'd0, reg_rdata[1]}, 0);
    chk("R10 irq on idle", {31'd0, irq}, {31'd0, ie});
    step();
    chk("R10 irq holds", {31'd0, irq}, {31'd0, ie});
    wr_word(32'h0);
    chk("R11 irq drops on ack", {31'd0, irq}, 0);
    step();
    wr_word(32'h4);
    chk("R11 no irq after re-enable", {31'd0, irq}, 0);
    wr_word(32'h0);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset rdata", reg_rdata, IDW);
    chk("R1 reset outs", {29'd0, irq, frame_start, wr_allow}, 0);

    wr_word(32'hFFFF_FFFF);
    chk("R2 R5 all ones readback", reg_rdata, IDW | KEEP);
    chk("R4 power-down start ignored", {31'd0, frame_start}, 0);
    chk("R4 power-down busy stays 0", {31'd0, reg_rdata[1]}, 0);
    wr_word(32'hA5A5_A5A4);
    chk("R5 R2 pattern readback", reg_rdata, IDW | (32'hA5A5_A5A4 & KEEP));
    wr_word(32'h0);
    chk("R5 cleared readback", reg_rdata, IDW);

    wr_word(32'h4000);
    chk("R8 idle abort no effect", reg_rdata, IDW);
    chk("R8 idle abort allow", {31'd0, wr_allow}, 0);

    for (int n = 0; n < 4; n++)
      for (int ab = 0; ab < 2; ab++)
        for (int ie = 0; ie < 2; ie++)
          run_frame(n, ab[0], ie[0]);

    wr_word(32'h1);
    step();
    wr_word(32'h1);
    chk("R4 start while busy no pulse", {31'd0, frame_start}, 0);
    chk("R4 start while busy stays busy", {31'd0, reg_rdata[1]}, 1);
    pulse_eof(); step();
    chk("R4 single frame ends", {31'd0, reg_rdata[1]}, 0);

    wr_word(32'h8001);
    chk("R9 initial pulse", {31'd0, frame_start}, 1);
    step();
    pulse_eof();
    chk("R9 debug repeat pulse", {31'd0, frame_start}, 1);
    step();
    chk("R9 repeat pulse one cycle", {31'd0, frame_start}, 0);
    chk("R9 frame ends", {31'd0, reg_rdata[1]}, 0);
    wr_word(32'h0);

    wr_word(32'h5);
    pulse_eof();
    wr_word(32'h0);
    chk("R12 idle and ack together busy", {31'd0, reg_rdata[1]}, 0);
    chk("R12 idle and ack together irq", {31'd0, irq}, 0);
    step();
    wr_word(32'h4);
    chk("R12 pending discarded", {31'd0, irq}, 0);

    wr_word(32'h5);
    pulse_eof(); step();
    chk("R10 irq before restart", {31'd0, irq}, 1);
    wr_word(32'h5);
    chk("R12 start clears pending", {31'd0, irq}, 0);
    pulse_eof(); step();
    chk("R10 irq second frame", {31'd0, irq}, 1);
    wr_word(32'h0);
    chk("R11 final ack", {31'd0, irq}, 0);

    finish_up();
  end
endmodule